// File: doc/BRIEF.md
# Indirect Diagnostic Buffer-RAM Access Port

This block is a register-mapped slave port for diagnostics. Host software uses it to read and write a word-wide buffer RAM through three registers: an upper-address register, a lower-address register and one data register. The upper-address register holds the top 4 address bits and a target-select bit. The select bit must be 0 for the buffer RAM to be the target. The lower-address register holds the bottom 16 bits, so the full RAM address is 20 bits. The address is loaded first and the data register is accessed after it.

An access to the data register does not finish at once. The first such access starts a RAM cycle and is answered with retry. Further accesses are also answered with retry until the RAM cycle has completed, and then the next access of the same kind completes. That access returns the word for a read, or takes the write. The RAM cycle takes a parameterised number of clocks.

Access is permitted only while the surrounding controller is stopped, or suspended with fast-suspend disabled. In any other state every access is refused with an error response. For stand-alone verification, the RAM is a small internal word array addressed by the low address bits.

Top module: `diag_ram_port`

## Requirements
- R1: After reset the upper field, the select bit and the lower field are all 0, no access is pending, and a cycle without `req_i` answers `rsp_o` = 0 (none) with `rdata_o` = 0.
- R2: Register select 0 is the upper-address register. A write stores `wdata_i[3:0]` as the upper field and `wdata_i[15]` as the select bit. Register select 1 is the lower-address register and stores all 16 bits. Reads of either register return the stored value (upper: select bit at bit 15, field at bits 3:0, other bits 0) with `rsp_o` = 1 (ok).
- R3: An access to the data register (select 2) when no access is pending is answered with `rsp_o` = 2 (retry) and starts a RAM cycle of its kind, read or write.
- R4: A pending read is answered with retry for `LAT` clocks after the clock that started it. After that, the next read returns the word at address {upper, lower} (low `RAM_AW` bits) with `rsp_o` = 1, and the port becomes idle.
- R5: A data write captures `wdata_i` when it starts. The RAM word is written `LAT` clocks later. Accesses before then get retry, and the next data write after completion gets ok. An access of the other kind after completion starts a new cycle with retry.
- R6: While the select bit is 1, data-register accesses get `rsp_o` = 3 (error) and the RAM is not touched.
- R7: Access is permitted only when `ctl_state_i` = 1 (stopped), or when `ctl_state_i` = 2 (suspended) with `fast_susp_i` = 0. In other states every access gets error and changes nothing.
- R8: The address registers do not auto-increment: they keep their values across data accesses.
- R9: A permitted write to either address register cancels any pending read or write, so a cancelled write never reaches the RAM.
- R10: Register select 3 is undefined and always answers error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_state_i | input | 2 | Controller state: 0 running, 1 stopped, 2 suspended, 3 initialising |
| fast_susp_i | input | 1 | Fast-suspend enabled |
| req_i | input | 1 | Access request this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 2 | Register select: 0 upper, 1 lower, 2 data, 3 undefined |
| wdata_i | input | 16 | Write data |
| rsp_o | output | 2 | Response: 0 none, 1 ok, 2 retry, 3 error |
| rdata_o | output | 16 | Read data, valid with an ok response to a read, else 0 |

## Verification
The case that is hardest to bring about is a cancellation that lands while a RAM write is still in flight. The stimulus starts a data write, receives a single retry, and then rewrites the lower-address register before the latency has run out. It then waits well past the latency and reads the same location back. The read must return the earlier word, not the cancelled one. Similar sequences flip the select bit or the controller state between a known write and its read-back, which shows from the ports alone that refused accesses left the RAM untouched.

// File: rtl/diag_pkg.sv
package diag_pkg;
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_OK    = 2'd1,
        RSP_RETRY = 2'd2,
        RSP_ERR   = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_BUSY = 2'd1,
        OP_DONE = 2'd2
    } op_st_e;

    localparam logic [1:0] REG_UPPER = 2'd0;
    localparam logic [1:0] REG_LOWER = 2'd1;
    localparam logic [1:0] REG_DATA  = 2'd2;

    localparam logic [1:0] CTL_RUN  = 2'd0;
    localparam logic [1:0] CTL_STOP = 2'd1;
    localparam logic [1:0] CTL_SUSP = 2'd2;
endpackage

// File: rtl/diag_gate.sv
module diag_gate
    import diag_pkg::*;
(
    input  logic [1:0] ctl_state_i,
    input  logic       fast_susp_i,
    output logic       allow_o
);
    always_comb begin
        allow_o = (ctl_state_i == CTL_STOP) ||
                  ((ctl_state_i == CTL_SUSP) && !fast_susp_i);
    end
endmodule

// File: rtl/diag_ram.sv
module diag_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/diag_ram_port.sv
module diag_ram_port
    import diag_pkg::*;
#(
    parameter int RAM_AW = 8,
    parameter int LAT    = 3,
    parameter int UP_W   = 4,
    parameter int LO_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ctl_state_i,
    input  logic        fast_susp_i,
    input  logic        req_i,
    input  logic        wr_i,
    input  logic [1:0]  sel_i,
    input  logic [15:0] wdata_i,
    output logic [1:0]  rsp_o,
    output logic [15:0] rdata_o
);
    localparam int DW   = 16;
    localparam int FA_W = UP_W + LO_W;
    localparam int CW   = $clog2(LAT + 1);
    localparam int PADW = DW - 1 - UP_W;

    typedef struct packed {
        logic            flash;
        logic [UP_W-1:0] up;
        logic [LO_W-1:0] lo;
        op_st_e          st;
        logic            kind_wr;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   wbuf;
        logic [DW-1:0]   rbuf;
    } port_s;

    port_s s_d, s_q;
    logic  allow;
    logic  cancel;
    logic  ram_we;
    logic  [FA_W-1:0] full_addr;
    logic  [DW-1:0]   ram_rd;
    rsp_e  rsp;
    logic  [DW-1:0]   rdata;

    diag_gate u_gate (
        .ctl_state_i (ctl_state_i),
        .fast_susp_i (fast_susp_i),
        .allow_o     (allow)
    );

    assign full_addr = {s_q.up, s_q.lo};

    diag_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .addr_i  (full_addr[RAM_AW-1:0]),
        .wdata_i (s_q.wbuf),
        .rdata_o (ram_rd)
    );

    always_comb begin
        s_d    = s_q;
        rsp    = RSP_NONE;
        rdata  = '0;
        cancel = 1'b0;
        ram_we = 1'b0;

        if (req_i) begin
            if (!allow || sel_i == 2'd3) begin
                rsp = RSP_ERR;
            end else if (sel_i == REG_UPPER) begin
                rsp = RSP_OK;
                if (wr_i) begin
                    s_d.flash = wdata_i[DW-1];
                    s_d.up    = wdata_i[UP_W-1:0];
                    cancel    = 1'b1;
                end else begin
                    rdata = {s_q.flash, {PADW{1'b0}}, s_q.up};
                end
            end else if (sel_i == REG_LOWER) begin
                rsp = RSP_OK;
                if (wr_i) begin
                    s_d.lo = wdata_i[LO_W-1:0];
                    cancel = 1'b1;
                end else begin
                    rdata = s_q.lo;
                end
            end else if (s_q.flash) begin
                rsp = RSP_ERR;
            end else begin
                rsp = RSP_RETRY;
                if (s_q.st == OP_IDLE ||
                    (s_q.st == OP_DONE && s_q.kind_wr != wr_i)) begin
                    s_d.st      = OP_BUSY;
                    s_d.kind_wr = wr_i;
                    s_d.cnt     = CW'(LAT);
                    s_d.wbuf    = wdata_i;
                end else if (s_q.st == OP_DONE) begin
                    rsp    = RSP_OK;
                    s_d.st = OP_IDLE;
                    if (!wr_i) begin
                        rdata = s_q.rbuf;
                    end
                end
            end
        end

        if (cancel) begin
            s_d.st = OP_IDLE;
        end else if (s_q.st == OP_BUSY) begin
            if (s_q.cnt == CW'(1)) begin
                s_d.st = OP_DONE;
                if (s_q.kind_wr) begin
                    ram_we = 1'b1;
                end else begin
                    s_d.rbuf = ram_rd;
                end
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_o   = rsp;
    assign rdata_o = rdata;

    // R1
    no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> (rsp_o == RSP_NONE && rdata_o == '0));

    // R3
    start_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == OP_BUSY && $past(s_q.st) != OP_BUSY) |-> $past(rsp_o) == RSP_RETRY);

    // R4
    ok_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i == REG_DATA && rsp_o == RSP_OK) |=> s_q.st == OP_IDLE);

    // R6
    flash_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flash |-> !ram_we);

    // R7
    gate_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !allow) |=> $stable(s_q));

    // R8
    addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i == REG_DATA) |=> ($stable(s_q.lo) && $stable(s_q.up)));

    // R9
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wr_i && allow && (sel_i == REG_UPPER || sel_i == REG_LOWER))
        |=> s_q.st == OP_IDLE);

    // R10
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i == 2'd3) |-> rsp_o == RSP_ERR);
endmodule

// File: tb/diag_ram_port_tb.sv
module diag_ram_port_tb_top;
    localparam int AW  = 8;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctl_state = 2'd1;
    logic        fast_susp = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [1:0]  rsp;
    logic [15:0] rdata;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_flash, m_up, m_lo, m_st, m_kind, m_cnt, m_wbuf, m_rbuf;
    int m_mem [int];

    always #10 clk = ~clk;

    diag_ram_port #(.RAM_AW(AW), .LAT(LAT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_state_i (ctl_state),
        .fast_susp_i (fast_susp),
        .req_i       (req),
        .wr_i        (wr),
        .sel_i       (sel),
        .wdata_i     (wdata),
        .rsp_o       (rsp),
        .rdata_o     (rdata)
    );

    always @(negedge clk) begin : model
        int ersp, erd, addr, nst;
        bit cancel, allow;
        if (!rst_n) begin
            m_flash = 0; m_up = 0; m_lo = 0; m_st = 0;
            m_kind = 0; m_cnt = 0; m_wbuf = 0; m_rbuf = 0;
        end else begin
            ersp = 0; erd = 0; cancel = 0; nst = m_st;
            addr = ((m_up << 16) | m_lo) & ((1 << AW) - 1);
            allow = (ctl_state == 2'd1) || (ctl_state == 2'd2 && !fast_susp);
            if (req) begin
                if (!allow || sel == 2'd3) ersp = 3;
                else if (sel == 2'd0) begin
                    ersp = 1;
                    if (wr) begin m_flash = int'(wdata[15]); m_up = int'(wdata[3:0]); cancel = 1; end
                    else erd = (m_flash << 15) | m_up;
                end else if (sel == 2'd1) begin
                    ersp = 1;
                    if (wr) begin m_lo = int'(wdata); cancel = 1; end
                    else erd = m_lo;
                end else if (m_flash != 0) ersp = 3;
                else if (m_st == 0 || (m_st == 2 && m_kind != int'(wr))) begin
                    ersp = 2; nst = 1; m_kind = int'(wr); m_cnt = LAT; m_wbuf = int'(wdata);
                end else if (m_st == 1) ersp = 2;
                else begin
                    ersp = 1; nst = 0;
                    if (!wr) erd = m_rbuf;
                end
            end
            if (cancel) nst = 0;
            else if (m_st == 1) begin
                if (m_cnt == 1) begin
                    nst = 2;
                    if (m_kind != 0) m_mem[addr] = m_wbuf;
                    else m_rbuf = m_mem.exists(addr) ? m_mem[addr] : 0;
                end else m_cnt = m_cnt - 1;
            end
            m_st = nst;
            total++;
            if (int'(rsp) != ersp || int'(rdata) != erd) begin
                bad++;
                $display("FAIL %s: rsp=%0d rdata=%h expected rsp=%0d rdata=%h",
                         cur_tag, rsp, rdata, ersp, erd[15:0]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input bit r, input bit w, input logic [1:0] s, input logic [15:0] d);
        @(posedge clk);
        #2;
        req = r; wr = w; sel = s; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 16'h0);
    endtask

    task automatic set_addr(input int a);
        cyc(1, 1, 2'd0, 16'(a >> 16) & 16'h000F);
        cyc(1, 1, 2'd1, 16'(a));
    endtask

    task automatic ram_write(input int a, input logic [15:0] d);
        set_addr(a);
        for (int i = 0; i < 20; i++) begin
            cyc(1, 1, 2'd2, d);
            #5;
            if (rsp == 2'd1) break;
        end
        idle(1);
    endtask

    task automatic ram_read(input int a);
        set_addr(a);
        for (int i = 0; i < 20; i++) begin
            cyc(1, 0, 2'd2, 16'h0);
            #5;
            if (rsp == 2'd1) break;
        end
        idle(1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        cur_tag = "R1";
        idle(1);
        cyc(1, 0, 2'd0, 0); cyc(1, 0, 2'd1, 0); idle(1);

        cur_tag = "R2";
        cyc(1, 1, 2'd0, 16'hFFFA); cyc(1, 0, 2'd0, 0);
        cyc(1, 1, 2'd0, 16'h0005); cyc(1, 1, 2'd1, 16'h1234);
        cyc(1, 0, 2'd0, 0); cyc(1, 0, 2'd1, 0); idle(1);

        cur_tag = "R5";
        ram_write(32'h00010, 16'hBEEF);
        ram_write(32'h00011, 16'h1357);
        ram_write(32'h500FF, 16'hA5A5);

        cur_tag = "R3 R4";
        ram_read(32'h00010);
        ram_read(32'h500FF);
        ram_read(32'h00011);

        cur_tag = "R8";
        cyc(1, 0, 2'd1, 0); cyc(1, 0, 2'd0, 0); idle(1);

        cur_tag = "R5 kind switch";
        set_addr(32'h00010);
        cyc(1, 0, 2'd2, 0); idle(LAT + 1);
        cyc(1, 1, 2'd2, 16'h4242); idle(LAT + 1);
        cyc(1, 1, 2'd2, 16'h4242); idle(1);
        ram_read(32'h00010);

        cur_tag = "R9";
        ram_write(32'h00020, 16'h7777);
        cyc(1, 1, 2'd2, 16'h1111);
        cyc(1, 1, 2'd1, 16'h0020);
        idle(LAT + 3);
        ram_read(32'h00020);
        cyc(1, 0, 2'd2, 0);
        cyc(1, 1, 2'd0, 16'h0000);
        idle(LAT + 2);

        cur_tag = "R6";
        cyc(1, 1, 2'd0, 16'h8000);
        cyc(1, 1, 2'd2, 16'hDEAD); cyc(1, 0, 2'd2, 0);
        idle(LAT + 2);
        cyc(1, 1, 2'd0, 16'h0000);
        ram_read(32'h00020);

        cur_tag = "R7";
        ctl_state = 2'd0;
        cyc(1, 1, 2'd1, 16'h0011); cyc(1, 1, 2'd2, 16'h0BAD); cyc(1, 0, 2'd0, 0);
        ctl_state = 2'd2; fast_susp = 1'b1;
        cyc(1, 1, 2'd2, 16'h0BAD); cyc(1, 0, 2'd1, 0);
        ctl_state = 2'd3; fast_susp = 1'b0;
        cyc(1, 0, 2'd2, 0); idle(LAT + 2);
        ctl_state = 2'd2;
        ram_read(32'h00020);
        ctl_state = 2'd1;

        cur_tag = "R10";
        cyc(1, 0, 2'd3, 0); cyc(1, 1, 2'd3, 16'hFFFF);
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule